// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an up-counter that advances on a single-cycle tick strobe from the system clock domain. A programmable prescaler divides the strobe by 1, 4 or 16 before it reaches the counter. On every prescaled tick the counter is compared with a period register. When the two are equal, the counter returns to zero instead of advancing, and a one-cycle match pulse is driven out. That pulse can be used as a shift clock by a neighbouring block.

A postscaler counts match events. After a selectable number of them, from 1 to 16, it sets a sticky interrupt flag. The flag stays set until software pulses a clear input.

Software reaches three registers through a simple write port and a combinational read port. The registers are the count, the period and the control. A write to the count or the control register restarts both scaler stages. A control write does not disturb the count.

Top module: `period_match_timer`

## Requirements
- R1: After reset, count reads 00h, period reads FFh, control reads 00h, and both match_o and irq_o are low.
- R2: Address 0 selects count, 1 selects period and 2 selects control, and a write to any of them reads back on the next cycle. Control bit 7 always reads 0, and address 3 reads 00h.
- R3: While control bit 2 (enable) is 0, the count does not change and no match occurs, however many tick strobes arrive.
- R4: Control bits 1:0 select the prescaler. 00 makes every enabled tick strobe a counting step, 01 makes every 4th one a step, and 10 or 11 makes every 16th one a step.
- R5: When a step occurs with count equal to period, the count becomes 00h and match_o is high for that one following cycle. A step with unequal values increments the count modulo 256.
- R6: Control bits 6:3 hold a value n. irq_o sets in the same cycle as the match pulse of every (n+1)th match.
- R7: irq_o stays set until a cycle with irq_clr_i high. If a new set and a clear fall in the same cycle, the set wins.
- R8: A write to count or to control clears the prescaler and postscaler progress. A control write leaves the count unchanged.
- R9: A count write takes priority over a step or wrap in the same cycle. The written value is loaded, and no match is produced in that cycle.
- R10: With period 00h, every step is a match and the count stays at 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle count strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| match_o | output | 1 | One-cycle period-match pulse |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The tick strobe is driven in several ways: continuously, on alternate cycles, and in sparse patterns. Each of the three prescale settings runs against these patterns, which separates a divider that counts strobes from one that counts clock cycles.

Some periods are shorter than the preloaded count, so the counter reaches the period only by wrapping past FFh. A period of 00h is also tried, which separates equality compare-and-wrap from overflow wrap.

Writes are placed in the same cycle as a match and in the middle of a prescale interval. These show whether write priority and scaler clearing are right.

Postscale ratios of 1, 4 and 16 are run while the clear strobe is pulsed, which checks the flag's sticky behaviour and the rule that a set wins over a clear.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

   typedef enum logic [1:0] {
      REG_COUNT  = 2'd0,
      REG_PERIOD = 2'd1,
      REG_CTRL   = 2'd2,
      REG_SPARE  = 2'd3
   } reg_sel_e;

   localparam int CTL_EN_BIT  = 2;
   localparam int CTL_PS_LSB  = 3;
   localparam int PS_FIELD_W  = 4;
   localparam int PRE_FIELD_W = 2;
   localparam int CTL_USED_W  = CTL_PS_LSB + PS_FIELD_W;
   localparam int PRE_CNT_W   = 4;

   // last prescaler count value before a step is released
   function automatic logic [PRE_CNT_W-1:0] presc_last(input logic [PRE_FIELD_W-1:0] sel);
      if (sel[1])      return PRE_CNT_W'(15);
      else if (sel[0]) return PRE_CNT_W'(3);
      else             return '0;
   endfunction

endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler
   import pmt_pkg::*;
#(
   parameter int DIV_W = PRE_CNT_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr_i,
   input  logic                   tick_i,
   input  logic                   en_i,
   input  logic [PRE_FIELD_W-1:0] sel_i,
   output logic                   step_o
);

   generate
      if (DIV_W < PRE_CNT_W) begin : g_bad_width
         $error("pmt_prescaler: DIV_W too small for divide by 16");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] last;
   logic             live;

   assign last   = DIV_W'(presc_last(sel_i));
   assign live   = tick_i && en_i && !clr_i;
   assign step_o = live && (div_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             div_q <= '0;
      else if (clr_i)         div_q <= '0;
      else if (live) begin
         if (div_q == last)   div_q <= '0;
         else                 div_q <= div_q + 1'b1;
      end
   end

endmodule

// File: rtl/pmt_count_core.sv
module pmt_count_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o,
   output logic             match_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             match_q;

   assign hit_o   = step_i && !load_i && (cnt_q == period_i);
   assign cnt_o   = cnt_q;
   assign match_o = match_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (hit_o)  cnt_q <= '0;
      else if (step_i) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= hit_o;
   end

endmodule

// File: rtl/pmt_postscaler.sv
module pmt_postscaler #(
   parameter int  PS_W     = 4,
   parameter bit  USE_POST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            evt_i,
   input  logic [PS_W-1:0] ratio_i,
   output logic            done_o
);

   generate
      if (PS_W < 1) begin : g_bad_width
         $error("pmt_postscaler: PS_W must be at least 1");
      end
      if (USE_POST) begin : g_count
         logic [PS_W-1:0] evt_q;
         assign done_o = evt_i && !clr_i && (evt_q == ratio_i);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       evt_q <= '0;
            else if (clr_i)   evt_q <= '0;
            else if (evt_i) begin
               if (evt_q == ratio_i) evt_q <= '0;
               else                  evt_q <= evt_q + 1'b1;
            end
         end
      end else begin : g_bypass
         assign done_o = evt_i;
      end
   endgenerate

endmodule

// File: rtl/period_match_timer.sv
module period_match_timer
   import pmt_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit USE_POST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_addr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic [1:0]       rd_addr_i,
   output logic [CNT_W-1:0] rd_data_o,
   input  logic             irq_clr_i,
   output logic             match_o,
   output logic             irq_o
);

   generate
      if (CNT_W <= CTL_USED_W) begin : g_bad_width
         $error("period_match_timer: CNT_W must exceed the control field width");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CTL_MASK = {{(CNT_W-CTL_USED_W){1'b0}}, {CTL_USED_W{1'b1}}};

   logic             cnt_wr, per_wr, ctl_wr, scaler_clr;
   logic [CNT_W-1:0] per_q, ctl_q, cnt_q;
   logic             step, hit, ps_done, irq_q;

   assign cnt_wr     = wr_en_i && (wr_addr_i == REG_COUNT);
   assign per_wr     = wr_en_i && (wr_addr_i == REG_PERIOD);
   assign ctl_wr     = wr_en_i && (wr_addr_i == REG_CTRL);
   assign scaler_clr = cnt_wr || ctl_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      per_q <= '1;
      else if (per_wr) per_q <= wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= wr_data_i & CTL_MASK;
   end

   pmt_prescaler #(.DIV_W(PRE_CNT_W)) presc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (scaler_clr),
      .tick_i (tick_i),
      .en_i   (ctl_q[CTL_EN_BIT]),
      .sel_i  (ctl_q[PRE_FIELD_W-1:0]),
      .step_o (step)
   );

   pmt_count_core #(.CNT_W(CNT_W)) core_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (cnt_wr),
      .load_val_i (wr_data_i),
      .step_i     (step),
      .period_i   (per_q),
      .cnt_o      (cnt_q),
      .hit_o      (hit),
      .match_o    (match_o)
   );

   pmt_postscaler #(.PS_W(PS_FIELD_W), .USE_POST(USE_POST)) post_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (scaler_clr),
      .evt_i   (hit),
      .ratio_i (ctl_q[CTL_PS_LSB +: PS_FIELD_W]),
      .done_o  (ps_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_q <= 1'b0;
      else if (ps_done)   irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
   end
   assign irq_o = irq_q;

   always_comb begin
      case (rd_addr_i)
         REG_COUNT:  rd_data_o = cnt_q;
         REG_PERIOD: rd_data_o = per_q;
         REG_CTRL:   rd_data_o = ctl_q;
         default:    rd_data_o = '0;
      endcase
   end

endmodule

// File: rtl/period_match_timer_chk.sv
module period_match_timer_chk
   import pmt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] ctl_q,
   input logic             cnt_wr,
   input logic             ctl_wr,
   input logic [CNT_W-1:0] wr_data_i,
   input logic             match_o,
   input logic             irq_o,
   input logic             irq_clr_i
);

   assert_disabled_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[CTL_EN_BIT] && !cnt_wr) |=> ($stable(cnt_q) && !match_o));

   assert_match_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> (cnt_q == '0));

   assert_irq_with_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> match_o);

   assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_clr_i) |=> irq_o);

   assert_ctl_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !cnt_wr) |=> $stable(cnt_q));

   assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> ((cnt_q == $past(wr_data_i)) && !match_o));

   assert_ctl_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[CNT_W-1:CTL_USED_W] == '0);

endmodule

bind period_match_timer period_match_timer_chk #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_q     (cnt_q),
   .ctl_q     (ctl_q),
   .cnt_wr    (cnt_wr),
   .ctl_wr    (ctl_wr),
   .wr_data_i (wr_data_i),
   .match_o   (match_o),
   .irq_o     (irq_o),
   .irq_clr_i (irq_clr_i)
);

// File: tb/period_match_timer_tb_top.sv
module period_match_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [1:0] wr_addr_i = 2'd0;
   logic [7:0] wr_data_i = 8'd0;
   logic [1:0] rd_addr_i = 2'd0;
   logic [7:0] rd_data_o;
   logic       irq_clr_i = 1'b0;
   logic       match_o, irq_o;

   always #10 clk = ~clk;

   period_match_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o), .irq_clr_i(irq_clr_i), .match_o(match_o), .irq_o(irq_o)
   );

   int    vectors = 0;
   int    miscompares = 0;
   bit    finished = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_cnt, m_per, m_ctl, m_pre, m_post;
   bit m_match, m_irq;

   task automatic model_reset();
      m_cnt = 0; m_per = 255; m_ctl = 0; m_pre = 0; m_post = 0;
      m_match = 0; m_irq = 0;
   endtask

   function automatic int model_read(int a);
      case (a)
         0: return m_cnt;
         1: return m_per;
         2: return m_ctl;
         default: return 0;
      endcase
   endfunction

   task automatic model_step();
      bit w_cnt, w_per, w_ctl, en, ev, hit, set_irq;
      int div, ratio, n_cnt, n_pre, n_post;
      w_cnt = wr_en_i && wr_addr_i == 2'd0;
      w_per = wr_en_i && wr_addr_i == 2'd1;
      w_ctl = wr_en_i && wr_addr_i == 2'd2;
      en    = m_ctl[2];
      div   = m_ctl[1] ? 16 : (m_ctl[0] ? 4 : 1);
      ratio = (m_ctl >> 3) & 15;
      ev    = tick_i && en && !w_cnt && !w_ctl && (m_pre == div - 1);
      hit   = ev && (m_cnt == m_per);
      if (w_cnt || w_ctl)   n_pre = 0;
      else if (tick_i && en) n_pre = (m_pre == div - 1) ? 0 : m_pre + 1;
      else                  n_pre = m_pre;
      if (w_cnt)    n_cnt = wr_data_i;
      else if (hit) n_cnt = 0;
      else if (ev)  n_cnt = (m_cnt + 1) % 256;
      else          n_cnt = m_cnt;
      set_irq = hit && (m_post == ratio);
      if (w_cnt || w_ctl) n_post = 0;
      else if (hit)       n_post = (m_post == ratio) ? 0 : m_post + 1;
      else                n_post = m_post;
      if (set_irq)        m_irq = 1;
      else if (irq_clr_i) m_irq = 0;
      m_match = hit;
      if (w_per) m_per = wr_data_i;
      if (w_ctl) m_ctl = wr_data_i & 8'h7F;
      m_cnt = n_cnt; m_pre = n_pre; m_post = n_post;
   endtask

   task automatic compare();
      int exp_rd;
      exp_rd = model_read(rd_addr_i);
      vectors++;
      if (rd_data_o !== 8'(exp_rd)) begin
         miscompares++;
         $display("FAIL %s: rd_data[addr %0d] actual %0h expected %0h", cur_req, rd_addr_i, rd_data_o, exp_rd);
      end
      if (match_o !== m_match) begin
         miscompares++;
         $display("FAIL %s: match_o actual %0b expected %0b", cur_req, match_o, m_match);
      end
      if (irq_o !== m_irq) begin
         miscompares++;
         $display("FAIL %s: irq_o actual %0b expected %0b", cur_req, irq_o, m_irq);
      end
   endtask

   task automatic cyc();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic wr(input int a, input int d);
      wr_en_i = 1; wr_addr_i = 2'(a); wr_data_i = 8'(d);
      cyc();
      wr_en_i = 0;
   endtask

   task automatic read_all();
      for (int a = 0; a < 4; a++) begin
         rd_addr_i = 2'(a);
         #1;
         compare();
      end
      rd_addr_i = 2'd0;
      #1;
   endtask

   // mode 0: every cycle, 1: alternate, 2: sparse
   task automatic run(input int n, input int mode);
      for (int i = 0; i < n; i++) begin
         case (mode)
            0: tick_i = 1;
            1: tick_i = (i % 2) == 0;
            default: tick_i = (i % 3) != 1 && (i % 7) != 0;
         endcase
         cyc();
      end
      tick_i = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      cur_req = "R1"; read_all();

      cur_req = "R2";
      wr(1, 8'h0A); wr(2, 8'hFF); wr(0, 8'h05);
      read_all();
      wr(2, 8'h00); read_all();

      cur_req = "R3";
      run(12, 0); read_all();

      cur_req = "R4";
      wr(1, 8'h05); wr(0, 0);
      wr(2, 8'h04); run(20, 0);
      wr(2, 8'h05); run(45, 1); run(30, 2);
      wr(2, 8'h06); run(100, 0);
      wr(2, 8'h07); run(70, 2);

      cur_req = "R5";
      wr(1, 8'h03); wr(0, 8'hFC); wr(2, 8'h04); run(30, 0); run(20, 2);

      cur_req = "R6";
      wr(1, 8'h02); wr(2, 8'h1C); run(40, 0);
      irq_clr_i = 1; cyc(); irq_clr_i = 0;
      wr(2, 8'h7C); run(60, 0);
      wr(1, 8'h00); run(20, 1);

      cur_req = "R7";
      wr(1, 8'h01); wr(2, 8'h04);
      for (int i = 0; i < 40; i++) begin
         tick_i = 1; irq_clr_i = (i % 5) == 0;
         cyc();
      end
      irq_clr_i = 1; tick_i = 0; cyc(); irq_clr_i = 0; cyc();

      cur_req = "R8";
      wr(1, 8'h06); wr(2, 8'h0D);
      run(6, 0); wr(2, 8'h0D); run(9, 0);
      wr(0, 8'h02); run(7, 1);
      wr(2, 8'h0D); run(30, 0); read_all();

      cur_req = "R9";
      wr(1, 8'h03); wr(2, 8'h04);
      for (int k = 0; k < 6; k++) begin
         run(3 + k, 0);
         tick_i = 1; wr(0, 8'h03 + k); tick_i = 0;
      end
      tick_i = 1; wr(0, 8'h80); run(150, 0);

      cur_req = "R10";
      wr(1, 8'h00); wr(0, 0); wr(2, 8'h04); run(15, 2);
      wr(2, 8'h05); run(24, 0); read_all();

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule